// File: doc/BRIEF.md
# Interval Counter Channel

A single 16-bit down-counting timer channel with a byte-wide host register interface. The host writes a control word that sets the operating mode and the byte format of the count. It then writes the initial count as one byte or two bytes and reads the count back live or through a frozen snapshot. The counter advances on a one-cycle `tick` enable that marks a counter-clock edge. A `gate` level, sampled in the system clock domain, either enables counting or triggers it, depending on the mode. The single output `tmr_out` makes one of six waveforms: a level that rises at terminal count, a retriggerable one-shot, a periodic one-tick low pulse, a square wave, and a one-tick strobe started either by a count write or by a gate edge.

Several channels can share one host bus. Each instance keeps only the control words whose channel field equals its `CHAN_ID` parameter. A count of zero counts as 65536. Counting is always binary.

Top module: `ictr_channel`

## Requirements
- R1: A control word (`wr_en` with `ctrl_sel` high) is taken only when bits 7:6 equal `CHAN_ID`; any other value, including 11, changes nothing. Bits 5:4 give the access format (00 latch command, 01 low byte only, 10 high byte only, 11 low then high). Bits 3:1 give the mode, where 110 means mode 2 and 111 means mode 3. Bit 0 is ignored.
- R2: In low-only format a data write sets the count to {00,byte}. In high-only format it sets the count to {byte,00}. In low-then-high format the first write gives the low byte and the second gives the high byte. The order flag that tracks this returns to "low next" on every accepted control word.
- R3: A latch command freezes the current count for reading until it has been read out in full in the current format. Further latch commands before then are ignored. A read returns the high byte in high-only format and on every second read in low-then-high format; otherwise it returns the low byte.
- R4: In mode 0 `tmr_out` goes low when the control word is written. It rises N+1 ticks after a count N is written, and stays high until a new count or control word.
- R5: In mode 0, writing the first byte of a two-byte count drives `tmr_out` low at once and stops counting. The second byte loads the new count on the next tick.
- R6: In modes 0 and 4, ticks with `gate` low do not decrement the count.
- R7: In mode 1, a gate rising edge arms a load. The next tick loads the count and drives `tmr_out` low for N ticks. A new rising edge reloads the count. `gate` never changes `tmr_out` between ticks.
- R8: In mode 2, the first tick after the count is written loads it with `tmr_out` high. `tmr_out` is low for the one tick in which the count is 1, and the count reloads on the following tick, which gives a period of N ticks.
- R9: In mode 3, `tmr_out` is high for (N+1)/2 ticks and low for N/2 ticks of each N-tick period. The high phase starts at the load tick.
- R10: In mode 4, `tmr_out` goes low for one tick N+1 ticks after a count N is written. Writing the first byte of a two-byte count does not disturb counting.
- R11: In mode 5, a gate rising edge starts the count on the next tick. `tmr_out` goes low for one tick N ticks later, and a new edge restarts the count.
- R12: In modes 2 and 3, `gate` low forces `tmr_out` high on the next clock and holds the count. A gate rising edge reloads the count on the next tick.
- R13: After reset `tmr_out` is high, the count is 0, the format is low-then-high, and ticks change nothing until a control word and a count are written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle |
| rd_en | input | 1 | Host read strobe, one cycle (advances the read byte order) |
| ctrl_sel | input | 1 | High selects the control word, low selects the count data |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Count byte selected by format and read order |
| tick | input | 1 | One-cycle enable marking a counter-clock edge |
| gate | input | 1 | Gate level, sampled each system clock |
| tmr_out | output | 1 | Counter output waveform |

## Verification
Each mode is driven with short counts, and `tmr_out` is compared after every tick against positions worked out from the period formulas. This shows the load tick apart from a counting tick. Mode 3 is run with one even count and one odd count, so that the high/low split and the odd-count correction are each shown. Gate patterns (low during counting, a rising edge before a tick, a second edge partway through a one-shot) separate pausing, forcing and retriggering. Byte-write sequences cover a lone first byte in modes 0 and 4, a control word between two bytes, and latch-then-relatch with ticks in between; these expose wrong byte order, a restarted latch, and a first byte that acts when it should not.

// File: rtl/ictr_channel.sv
module ictr_channel #(
  parameter logic [1:0] CHAN_ID = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       ctrl_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       tick,
  input  logic       gate,
  output logic       tmr_out
);
  localparam int CW = 16;

  logic [2:0]    mode_q;
  logic [1:0]    acc;
  logic [CW-1:0] cr, ce, lat;
  logic          lat_v, wr_hi, rd_hi, load_pend, run, armed, trig, gate_q;

  logic          cw_hit, data_wr, commit, first_byte;
  logic [CW-1:0] cr_nxt, src, half_ld, hi_ld;
  logic [2:0]    mode_new;

  assign cw_hit   = wr_en && ctrl_sel && (wdata[7:6] == CHAN_ID);
  assign data_wr  = wr_en && !ctrl_sel;
  assign mode_new = wdata[2] ? {1'b0, wdata[2:1]} : wdata[3:1];
  assign half_ld  = {cr[CW-1:1], 1'b0};
  assign hi_ld    = half_ld + (cr[0] ? 16'd2 : 16'd0);
  assign src      = lat_v ? lat : ce;
  assign rdata    = (acc == 2'b10 || (acc == 2'b11 && rd_hi)) ? src[15:8] : src[7:0];

  always_comb begin
    cr_nxt     = cr;
    commit     = 1'b0;
    first_byte = 1'b0;
    if (data_wr) begin
      case (acc)
        2'b01:   begin cr_nxt = {8'h00, wdata}; commit = 1'b1; end
        2'b10:   begin cr_nxt = {wdata, 8'h00}; commit = 1'b1; end
        default: begin
          if (!wr_hi) begin cr_nxt = {cr[15:8], wdata}; first_byte = 1'b1; end
          else        begin cr_nxt = {wdata, cr[7:0]};  commit = 1'b1; end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'd0; acc <= 2'b11;
      cr <= '0; ce <= '0; lat <= '0;
      lat_v <= 1'b0; wr_hi <= 1'b0; rd_hi <= 1'b0;
      load_pend <= 1'b0; run <= 1'b0; armed <= 1'b0;
      trig <= 1'b0; gate_q <= 1'b0; tmr_out <= 1'b1;
    end else begin
      gate_q <= gate;
      if (gate && !gate_q) trig <= 1'b1;
      else if (tick)       trig <= 1'b0;

      if (tick) begin
        case (mode_q)
          3'd0: begin
            if (load_pend) begin
              ce <= cr; load_pend <= 1'b0; run <= 1'b1;
            end else if (run && gate) begin
              ce <= ce - 16'd1;
              if (ce == 16'd1) tmr_out <= 1'b1;
            end
          end
          3'd1: begin
            if (trig && armed) begin
              ce <= cr; tmr_out <= 1'b0; run <= 1'b1;
            end else if (run) begin
              ce <= ce - 16'd1;
              if (ce == 16'd1) begin tmr_out <= 1'b1; run <= 1'b0; end
            end
          end
          3'd2: begin
            if (load_pend || (trig && armed && gate)) begin
              ce <= cr; tmr_out <= 1'b1; run <= 1'b1; load_pend <= 1'b0;
            end else if (run && gate) begin
              if (ce == 16'd1) begin
                ce <= cr; tmr_out <= 1'b1;
              end else begin
                ce <= ce - 16'd1;
                if (ce == 16'd2) tmr_out <= 1'b0;
              end
            end
          end
          3'd3: begin
            if (load_pend || (trig && armed && gate)) begin
              ce <= hi_ld; tmr_out <= 1'b1; run <= 1'b1; load_pend <= 1'b0;
            end else if (run && gate) begin
              if (ce == 16'd2) begin
                tmr_out <= !tmr_out;
                ce <= tmr_out ? half_ld : hi_ld;
              end else begin
                ce <= ce - 16'd2;
              end
            end
          end
          3'd4: begin
            if (!tmr_out) tmr_out <= 1'b1;
            if (load_pend) begin
              ce <= cr; load_pend <= 1'b0; run <= 1'b1;
            end else if (run && gate) begin
              ce <= ce - 16'd1;
              if (ce == 16'd1) begin tmr_out <= 1'b0; run <= 1'b0; end
            end
          end
          default: begin
            if (!tmr_out) tmr_out <= 1'b1;
            if (trig && armed) begin
              ce <= cr; run <= 1'b1;
            end else if (run) begin
              ce <= ce - 16'd1;
              if (ce == 16'd1) begin tmr_out <= 1'b0; run <= 1'b0; end
            end
          end
        endcase
      end

      if ((mode_q == 3'd2 || mode_q == 3'd3) && !gate) tmr_out <= 1'b1;

      if (cw_hit) begin
        if (wdata[5:4] == 2'b00) begin
          if (!lat_v) begin lat <= ce; lat_v <= 1'b1; end
        end else begin
          mode_q <= mode_new; acc <= wdata[5:4];
          wr_hi <= 1'b0; rd_hi <= 1'b0; lat_v <= 1'b0;
          load_pend <= 1'b0; run <= 1'b0; armed <= 1'b0; trig <= 1'b0;
          tmr_out <= (mode_new != 3'd0);
        end
      end else if (data_wr) begin
        cr <= cr_nxt;
        if (first_byte) begin
          wr_hi <= 1'b1;
          if (mode_q == 3'd0) begin
            tmr_out <= 1'b0; run <= 1'b0; load_pend <= 1'b0;
          end
        end
        if (commit) begin
          wr_hi <= 1'b0;
          armed <= 1'b1;
          case (mode_q)
            3'd0:      begin load_pend <= 1'b1; tmr_out <= 1'b0; end
            3'd4:      load_pend <= 1'b1;
            3'd2, 3'd3: if (!run) load_pend <= 1'b1;
            default:   ;
          endcase
        end
      end

      if (rd_en && !ctrl_sel) begin
        if (acc == 2'b11) rd_hi <= !rd_hi;
        if (lat_v && (acc != 2'b11 || rd_hi)) lat_v <= 1'b0;
      end
    end
  end

  a_r4_ctrl_mode0_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_hit && wdata[5:4] != 2'b00 && wdata[3:1] == 3'd0) |=> !tmr_out);

  a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && $rose(tmr_out)) |-> $past(tick));

  a_r5_first_byte_low: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && mode_q == 3'd0 && acc == 2'b11 && !wr_hi) |=> !tmr_out);

  a_r3_latch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lat_v |=> $stable(lat));

  a_r7_gate_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && !tick && !wr_en) |=> $stable(tmr_out));

  // R11 shares this check with R10
  a_r10_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd4 || mode_q == 3'd5) && !tmr_out && tick && !wr_en) |=> tmr_out);

  a_r12_gate_low_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 3'd2 || mode_q == 3'd3) && !gate && !wr_en) |=> tmr_out);
endmodule

// File: tb/tb_ictr_channel.sv
module tb_ictr_channel;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ctrl_sel = 1'b0, tick = 1'b0, gate = 1'b1;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic tmr_out;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = !clk;

  ictr_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ctrl_sel(ctrl_sel),
    .wdata(wdata), .rdata(rdata), .tick(tick), .gate(gate), .tmr_out(tmr_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; ctrl_sel = c; wdata = d;
    @(negedge clk); wr_en = 1'b0; ctrl_sel = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); v = rdata; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic gate_rise;
    @(negedge clk); gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    chk("R13 out after reset", tmr_out, 1);
    tk(3);
    chk("R13 no counting before setup", tmr_out, 1);
    rd(v);
    chk("R13 count zero", v, 0);
  endtask

  task automatic t_mode0;
    wr(1'b1, 8'h30);
    chk("R4 control word drives low", tmr_out, 0);
    wr(1'b0, 8'd3); wr(1'b0, 8'd0);
    tk(3); chk("R4 still low at N", tmr_out, 0);
    tk(1); chk("R4 high at N+1", tmr_out, 1);
    wr(1'b0, 8'd2);
    chk("R5 first byte forces low", tmr_out, 0);
    tk(5); chk("R5 counting stopped", tmr_out, 0);
    wr(1'b0, 8'd0);
    tk(2); chk("R5 new count low", tmr_out, 0);
    tk(1); chk("R5 new count rises", tmr_out, 1);
  endtask

  task automatic t_gate_pause;
    wr(1'b1, 8'h30); wr(1'b0, 8'd4); wr(1'b0, 8'd0);
    tk(1);
    @(negedge clk); gate = 1'b0;
    tk(3); chk("R6 paused with gate low", tmr_out, 0);
    @(negedge clk); gate = 1'b1;
    tk(3); chk("R6 resume count", tmr_out, 0);
    tk(1); chk("R6 resume reaches end", tmr_out, 1);
  endtask

  task automatic t_mode1;
    wr(1'b1, 8'h32); wr(1'b0, 8'd3); wr(1'b0, 8'd0);
    chk("R7 initial high", tmr_out, 1);
    tk(3); chk("R7 no trigger stays high", tmr_out, 1);
    gate_rise();
    chk("R7 gate edge alone no change", tmr_out, 1);
    tk(1); chk("R7 low after trigger tick", tmr_out, 0);
    tk(2); chk("R7 low through N", tmr_out, 0);
    tk(1); chk("R7 high after N", tmr_out, 1);
    gate_rise();
    tk(2);
    gate_rise();
    tk(1); chk("R7 retrigger low", tmr_out, 0);
    tk(2); chk("R7 retrigger extends", tmr_out, 0);
    tk(1); chk("R7 retrigger ends", tmr_out, 1);
  endtask

  task automatic t_periodic(input string tag, input logic [7:0] cw, input int n,
                            input bit sq);
    wr(1'b1, cw); wr(1'b0, n[7:0]); wr(1'b0, 8'd0);
    for (int k = 1; k <= 9; k++) begin
      int p, e;
      tk(1);
      p = (k - 1) % n;
      if (sq) e = (p < (n + 1) / 2) ? 1 : 0;
      else    e = (p == n - 1) ? 0 : 1;
      chk(tag, tmr_out, e);
    end
  endtask

  task automatic t_mode23_gate;
    wr(1'b1, 8'h34); wr(1'b0, 8'd3); wr(1'b0, 8'd0);
    tk(3); chk("R8 low at count one", tmr_out, 0);
    @(negedge clk); gate = 1'b0;
    @(negedge clk); chk("R12 gate low forces high", tmr_out, 1);
    tk(3); chk("R12 held while gate low", tmr_out, 1);
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
    tk(2); chk("R12 reload after edge", tmr_out, 1);
    tk(1); chk("R12 low N ticks after edge", tmr_out, 0);
  endtask

  task automatic t_mode4;
    wr(1'b1, 8'h38); wr(1'b0, 8'd4); wr(1'b0, 8'd0);
    tk(2);
    wr(1'b0, 8'd9);
    tk(2); chk("R10 first byte ignored", tmr_out, 1);
    tk(1); chk("R10 strobe at N+1", tmr_out, 0);
    tk(1); chk("R10 strobe one tick", tmr_out, 1);
    wr(1'b1, 8'h70);
    chk("R1 other channel ignored", tmr_out, 1);
    wr(1'b1, 8'hF0);
    chk("R1 code 11 ignored", tmr_out, 1);
  endtask

  task automatic t_mode5;
    wr(1'b1, 8'h3A); wr(1'b0, 8'd2); wr(1'b0, 8'd0);
    tk(2); chk("R11 idle without edge", tmr_out, 1);
    gate_rise();
    tk(2); chk("R11 counting high", tmr_out, 1);
    tk(1); chk("R11 strobe low", tmr_out, 0);
    tk(1); chk("R11 strobe ends", tmr_out, 1);
  endtask

  task automatic t_formats;
    wr(1'b1, 8'h18); wr(1'b0, 8'd5);
    tk(5); chk("R2 low-only before end", tmr_out, 1);
    tk(1); chk("R2 low-only strobe", tmr_out, 0);
    wr(1'b1, 8'h28); wr(1'b0, 8'd1);
    tk(256); chk("R2 high-only before end", tmr_out, 1);
    tk(1); chk("R2 high-only strobe", tmr_out, 0);
    wr(1'b1, 8'h38); wr(1'b0, 8'h07);
    wr(1'b1, 8'h38); wr(1'b0, 8'd3); wr(1'b0, 8'd0);
    tk(3); chk("R2 order reset by control word", tmr_out, 1);
    tk(1); chk("R2 order reset strobe", tmr_out, 0);
  endtask

  task automatic t_latch;
    logic [7:0] v;
    wr(1'b1, 8'h34); wr(1'b0, 8'd100); wr(1'b0, 8'd0);
    tk(11);
    wr(1'b1, 8'h00);
    tk(5);
    wr(1'b1, 8'h00);
    tk(3);
    rd(v); chk("R3 latched low byte", v, 90);
    rd(v); chk("R3 latched high byte", v, 0);
    rd(v); chk("R3 live after readout", v, 82);
    rd(v); chk("R3 live high byte", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode0();
    t_gate_pause();
    t_mode1();
    t_periodic("R8 rate period", 8'h34, 3, 1'b0);
    t_periodic("R1 R8 alias code period", 8'h3D, 4, 1'b0);
    t_periodic("R9 even square", 8'h36, 4, 1'b1);
    t_periodic("R9 odd square", 8'h3E, 5, 1'b1);
    t_mode23_gate();
    t_mode4();
    t_mode5();
    t_formats();
    t_latch();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule